// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog for a system-on-chip. It counts ticks of a slow clock enable and issues a one-cycle system reset request when software fails to service it in time. Software services the watchdog by writing one key byte to a write-only service register. Any other byte written there is treated as a runaway program, and the reset request is raised at once.

In window mode, each period begins with a closed interval during which servicing is forbidden. A correct key written during that interval also raises the reset request. After the closed interval, an open interval of the timeout length follows. A separate early-warning flag sets at a programmable tick count after the last restart. The flag drives a maskable interrupt. An always-on bit locks the watchdog running until the next reset.

Every interval is chosen by a 4-bit power-of-two code: code c gives 8 × 2^c ticks for c up to 11, and codes 12 to 15 behave as 11. The register bus is a plain synchronous byte interface. Writes are strobed by `bus_we`, and read data follows `bus_addr` combinationally.

Top module: `window_watchdog`

## Requirements
- R1: After reset, the registers read as follows: offset 0x0 (control) reads 0x00, offset 0x1 (configuration) reads 0xBB, offset 0x2 (warning offset) reads 0x0B, offsets 0x4/0x5 (interrupt enable), 0x6 (flag) and 0x7 (status) read 0x00, and `rst_req` and `ew_irq` are low.
- R2: The timeout code is configuration bits 3:0. With control bit 1 (enable) set and window mode off, `rst_req` rises after 8 × 2^code counted ticks since enable, service or the previous expiry. Codes 12 to 15 give 16384 ticks.
- R3: `rst_req` is high for exactly one cycle per event, and counting then restarts from zero.
- R4: Only clock cycles with `tick` high advance the count.
- R5: Writing 0xA5 to offset 0x8 while enabled and outside a closed window restarts the count without a reset request. Offset 0x8 always reads 0x00.
- R6: Writing any other byte to offset 0x8 while enabled raises `rst_req` in the cycle after the write.
- R7: With control bit 2 (window mode) set, the closed window lasts 8 × 2^w ticks after each restart, where w is configuration bits 7:4. A 0xA5 write inside it raises `rst_req`. Without service, `rst_req` rises after the closed length plus the timeout length.
- R8: The early-warning flag (offset 0x6 bit 0) sets on the tick at which the count since the last restart reaches 8 × 2^e, where e is offset 0x2 bits 3:0. Writing 1 to that bit clears the flag, and writing 0 has no effect.
- R9: The interrupt enable is bit 0. Writing 1 to offset 0x5 sets it, writing 1 to offset 0x4 clears it, and both offsets read it back. `ew_irq` is the flag ANDed with the enable.
- R10: Control keeps only bits 1, 2 and 7, and all other control bits read as 0. Configuration keeps all 8 bits. Offset 0x2 keeps only bits 3:0, and offset 0x3 reads 0x00.
- R11: Once control bit 7 (always-on) is set, it cannot be cleared until reset, and neither can an enable that is already set. Control bit 2 stays writable.
- R12: Status bit 7 reads 1 during the two cycles after a write to offset 0x0, 0x1 or 0x8, and reads 0 otherwise.
- R13: While enable is clear, the count holds at zero, writes to offset 0x8 have no effect, and `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow-clock enable; each high cycle counts one tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
A register write takes effect at the clock edge that samples it, and read data follows the address with no delay. A reset request caused by a write is therefore visible right after the write edge. A timeout or warning that needs N ticks appears right after the N-th counted tick edge. The bench drives and samples one time unit after each rising edge and counts edges from the enabling write. It compares that count with 8 × 2^code, the sum of the closed and open lengths, or the number of delivered ticks. For the two busy cycles, it reads status immediately after the write edge and again after each of the next two edges.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned CODE_W   = 4;
    localparam int unsigned BASE_LOG = 3;   // code 0 means 2**BASE_LOG ticks
    localparam int unsigned CODE_MAX = 11;  // larger codes saturate here
    localparam int unsigned TICKS_W  = BASE_LOG + CODE_MAX + 1;
    localparam int unsigned CNT_W    = TICKS_W + 1;  // closed + open span
    localparam int unsigned BUSY_CYC = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG     = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_EWOFS   = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_IEN_CLR = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_IEN_SET = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_FLAG    = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_SVC     = 4'h8;

    localparam logic [DATA_W-1:0] SVC_KEY = 8'hA5;

    localparam int unsigned EN_BIT   = 1;
    localparam int unsigned WIN_BIT  = 2;
    localparam int unsigned AON_BIT  = 7;
    localparam int unsigned BUSY_BIT = 7;

    localparam logic [CODE_W-1:0] CODE_RST = 4'hB;

    typedef struct packed {
        logic aon;
        logic win;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/wdg_period_dec.sv
module wdg_period_dec #(
    parameter int unsigned CODE_W   = wdg_pkg::CODE_W,
    parameter int unsigned BASE_LOG = wdg_pkg::BASE_LOG,
    parameter int unsigned CODE_MAX = wdg_pkg::CODE_MAX,
    parameter int unsigned TICKS_W  = wdg_pkg::TICKS_W
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic [TICKS_W-1:0] ticks_o
);
    logic [CODE_W-1:0] eff_code;

    // Saturate out-of-range codes at the longest supported interval.
    assign eff_code = (code_i > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code_i;
    assign ticks_o  = TICKS_W'(1) << (eff_code + CODE_W'(BASE_LOG));

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned CW   = CODE_W,
    parameter int unsigned BUSY = BUSY_CYC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic          ew_hit_i,
    output ctrl_t         ctrl_o,
    output logic [CW-1:0] per_code_o,
    output logic [CW-1:0] win_code_o,
    output logic [CW-1:0] ew_code_o,
    output logic          svc_good_o,
    output logic          svc_bad_o,
    output logic          ew_irq_o
);
    localparam int unsigned BUSY_W = $clog2(BUSY + 1);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CW-1:0]     per;
        logic [CW-1:0]     win;
        logic [CW-1:0]     ew;
        logic              ien;
        logic              flag;
        logic [BUSY_W-1:0] busy;
    } regs_t;

    regs_t q, d;
    logic  svc_wr;

    assign svc_wr     = bus_we_i && (bus_addr_i == OFS_SVC) && q.ctrl.en;
    assign svc_good_o = svc_wr && (bus_wdata_i == SVC_KEY);
    assign svc_bad_o  = svc_wr && (bus_wdata_i != SVC_KEY);

    always_comb begin
        d = q;
        if (q.busy != '0) begin
            d.busy = q.busy - BUSY_W'(1);
        end
        if (bus_we_i) begin
            case (bus_addr_i)
                OFS_CTRL: begin
                    d.ctrl.win = bus_wdata_i[WIN_BIT];
                    d.ctrl.aon = bus_wdata_i[AON_BIT] | q.ctrl.aon;
                    d.ctrl.en  = bus_wdata_i[EN_BIT] | (q.ctrl.aon & q.ctrl.en);
                    d.busy     = BUSY_W'(BUSY);
                end
                OFS_CFG: begin
                    d.per  = bus_wdata_i[CW-1:0];
                    d.win  = bus_wdata_i[2*CW-1:CW];
                    d.busy = BUSY_W'(BUSY);
                end
                OFS_EWOFS: d.ew = bus_wdata_i[CW-1:0];
                OFS_IEN_CLR: if (bus_wdata_i[0]) d.ien = 1'b0;
                OFS_IEN_SET: if (bus_wdata_i[0]) d.ien = 1'b1;
                OFS_FLAG:    if (bus_wdata_i[0]) d.flag = 1'b0;
                OFS_SVC:     d.busy = BUSY_W'(BUSY);
                default: ;
            endcase
        end
        // A new warning event outranks a clear in the same cycle.
        if (ew_hit_i) begin
            d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl <= '0;
            q.per  <= CODE_RST;
            q.win  <= CODE_RST;
            q.ew   <= CODE_RST;
            q.ien  <= 1'b0;
            q.flag <= 1'b0;
            q.busy <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_CTRL: begin
                bus_rdata_o[EN_BIT]  = q.ctrl.en;
                bus_rdata_o[WIN_BIT] = q.ctrl.win;
                bus_rdata_o[AON_BIT] = q.ctrl.aon;
            end
            OFS_CFG:     bus_rdata_o = {q.win, q.per};
            OFS_EWOFS:   bus_rdata_o[CW-1:0] = q.ew;
            OFS_IEN_CLR: bus_rdata_o[0] = q.ien;
            OFS_IEN_SET: bus_rdata_o[0] = q.ien;
            OFS_FLAG:    bus_rdata_o[0] = q.flag;
            OFS_STAT:    bus_rdata_o[BUSY_BIT] = (q.busy != '0);
            default: ;
        endcase
    end

    assign ctrl_o     = q.ctrl;
    assign per_code_o = q.per;
    assign win_code_o = q.win;
    assign ew_code_o  = q.ew;
    assign ew_irq_o   = q.flag & q.ien;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !(bus_we_i && bus_addr_i == OFS_FLAG && bus_wdata_i[0])) |=> q.flag); // R8
    AST_AON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.aon && q.ctrl.en) |=> (q.ctrl.aon && q.ctrl.en)); // R11
    AST_BUSY_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == OFS_CFG) |=> (bus_rdata_o[BUSY_BIT] || bus_addr_i != OFS_STAT) && q.busy != '0); // R12

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int unsigned TW = TICKS_W,
    parameter int unsigned NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          win_en_i,
    input  logic [TW-1:0] per_ticks_i,
    input  logic [TW-1:0] win_ticks_i,
    input  logic [TW-1:0] ew_ticks_i,
    input  logic          svc_good_i,
    input  logic          svc_bad_i,
    output logic          rst_req_o,
    output logic          ew_hit_o
);
    typedef struct packed {
        logic [NW-1:0] cnt;
        logic          rst_req;
    } core_t;

    core_t q, d;
    logic [NW-1:0] deadline;
    logic [NW-1:0] cnt_inc;
    logic          closed;

    assign deadline = (win_en_i ? NW'(win_ticks_i) : '0) + NW'(per_ticks_i);
    assign cnt_inc  = q.cnt + NW'(1);
    assign closed   = win_en_i && (q.cnt < NW'(win_ticks_i));

    always_comb begin
        d         = q;
        d.rst_req = 1'b0;
        ew_hit_o  = 1'b0;
        if (!en_i) begin
            d.cnt = '0;
        end else if (svc_bad_i || (svc_good_i && closed)) begin
            d.cnt     = '0;
            d.rst_req = 1'b1;
        end else if (svc_good_i) begin
            d.cnt = '0;
        end else if (tick_i) begin
            ew_hit_o = (cnt_inc == NW'(ew_ticks_i));
            if (cnt_inc >= deadline) begin
                d.cnt     = '0;
                d.rst_req = 1'b1;
            end else begin
                d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rst_req_o = q.rst_req;

    AST_CNT_BELOW_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && $stable(deadline)) |-> (q.cnt < deadline)); // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rst_req && $past(q.rst_req)) |-> $past(svc_good_i || svc_bad_i)); // R3
    AST_EARLY_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && svc_good_i && closed) |=> q.rst_req); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!q.rst_req && q.cnt == '0)); // R13

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              ew_irq
);
    localparam int unsigned NUM_DEC = 3;
    localparam int unsigned DEC_PER = 0;
    localparam int unsigned DEC_WIN = 1;
    localparam int unsigned DEC_EW  = 2;

    ctrl_t              ctrl;
    logic               svc_good;
    logic               svc_bad;
    logic               ew_hit;
    logic [CODE_W-1:0]  code_arr  [NUM_DEC];
    logic [TICKS_W-1:0] ticks_arr [NUM_DEC];

    wdg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .ew_hit_i    (ew_hit),
        .ctrl_o      (ctrl),
        .per_code_o  (code_arr[DEC_PER]),
        .win_code_o  (code_arr[DEC_WIN]),
        .ew_code_o   (code_arr[DEC_EW]),
        .svc_good_o  (svc_good),
        .svc_bad_o   (svc_bad),
        .ew_irq_o    (ew_irq)
    );

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
        wdg_period_dec u_dec (
            .code_i  (code_arr[i]),
            .ticks_o (ticks_arr[i])
        );
    end

    wdg_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .en_i        (ctrl.en),
        .win_en_i    (ctrl.win),
        .per_ticks_i (ticks_arr[DEC_PER]),
        .win_ticks_i (ticks_arr[DEC_WIN]),
        .ew_ticks_i  (ticks_arr[DEC_EW]),
        .svc_good_i  (svc_good),
        .svc_bad_i   (svc_bad),
        .rst_req_o   (rst_req),
        .ew_hit_o    (ew_hit)
    );

endmodule

// File: tb/window_watchdog_tb.sv
`timescale 1ns/100ps
module window_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rst_req;
    logic       ew_irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    window_watchdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .ew_irq    (ew_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] v);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, int exp, string req);
        bus_addr = a;
        #0.5;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic do_reset();
        bus_we = 1'b0; tick = 1'b1;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // Edges from now until rst_req is observed high.
    task automatic wait_rst(int limit, output int n);
        n = 0;
        while (n < limit) begin
            step();
            n++;
            if (rst_req) break;
        end
    endtask

    task automatic t_r1_reset();
        do_reset();
        rd(4'h0, 8'h00, "R1 ctrl");
        rd(4'h1, 8'hBB, "R1 cfg");
        rd(4'h2, 8'h0B, "R1 ewofs");
        step();
        rd(4'h4, 0, "R1 ien");
        rd(4'h6, 0, "R1 flag");
        rd(4'h7, 0, "R1 status");
        check("R1 rst_req", int'(rst_req), 0);
        check("R1 ew_irq", int'(ew_irq), 0);
    endtask

    task automatic t_r2_r3_timeout();
        int n;
        do_reset();
        wr(4'h1, 8'hB0);          // timeout code 0: 8 ticks
        wr(4'h0, 8'h02);
        wait_rst(100, n);
        check("R2 code0 ticks", n, 8);
        step();
        check("R3 pulse width", int'(rst_req), 0);
        wait_rst(100, n);
        check("R3 restart after expiry", n, 7);
        do_reset();
        wr(4'h1, 8'hB2);          // code 2: 32 ticks
        wr(4'h0, 8'h02);
        wait_rst(100, n);
        check("R2 code2 ticks", n, 32);
        do_reset();
        wr(4'h1, 8'hBF);          // code 15 behaves as 11
        wr(4'h0, 8'h02);
        wait_rst(20000, n);
        check("R2 clamp code15", n, 16384);
    endtask

    task automatic t_r4_tick();
        int ticks = 0;
        do_reset();
        wr(4'h1, 8'hB0);
        tick = 1'b0;
        wr(4'h0, 8'h02);
        for (int i = 0; i < 200; i++) begin
            tick = (i % 3 == 0);
            step();
            if (tick) ticks++;
            if (rst_req) break;
        end
        tick = 1'b1;
        check("R4 ticks counted", ticks, 8);
    endtask

    task automatic t_r5_r6_service();
        int n;
        do_reset();
        wr(4'h1, 8'hB0);
        wr(4'h0, 8'h02);
        repeat (5) step();
        wr(4'h8, 8'hA5);
        check("R5 no reset on key", int'(rst_req), 0);
        rd(4'h8, 0, "R5 svc reads zero");
        wait_rst(100, n);
        check("R5 restart after key", n, 8);
        do_reset();
        wr(4'h1, 8'hB3);
        wr(4'h0, 8'h02);
        repeat (2) step();
        wr(4'h8, 8'h5A);
        check("R6 bad key reset", int'(rst_req), 1);
        step();
        check("R6 bad key pulse ends", int'(rst_req), 0);
    endtask

    task automatic t_r7_window();
        int n;
        do_reset();
        wr(4'h1, 8'h01);          // closed 8, open 16
        wr(4'h0, 8'h06);
        wait_rst(200, n);
        check("R7 closed plus open", n, 24);
        repeat (3) step();
        wr(4'h8, 8'hA5);
        check("R7 early key resets", int'(rst_req), 1);
        repeat (10) step();
        wr(4'h8, 8'hA5);
        check("R7 open key accepted", int'(rst_req), 0);
        wait_rst(200, n);
        check("R7 restart after open key", n, 24);
    endtask

    task automatic t_r8_r9_warning();
        do_reset();
        wr(4'h1, 8'h03);          // timeout 64
        wr(4'h2, 8'h01);          // warning at 16
        wr(4'h5, 8'h01);
        rd(4'h4, 1, "R9 ien via clr addr");
        rd(4'h5, 1, "R9 ien via set addr");
        wr(4'h0, 8'h02);
        repeat (15) step();
        check("R8 no flag before offset", int'(ew_irq), 0);
        step();
        check("R9 irq at offset", int'(ew_irq), 1);
        rd(4'h6, 1, "R8 flag set");
        wr(4'h6, 8'h00);
        rd(4'h6, 1, "R8 write 0 ignored");
        wr(4'h6, 8'h01);
        rd(4'h6, 0, "R8 write 1 clears");
        wr(4'h4, 8'h01);
        rd(4'h5, 0, "R9 ien cleared");
        do_reset();
        wr(4'h1, 8'h01);
        wr(4'h2, 8'h00);          // warning at 8
        wr(4'h0, 8'h02);
        repeat (8) step();
        rd(4'h6, 1, "R8 flag at 8");
        check("R9 masked irq", int'(ew_irq), 0);
        wr(4'h5, 8'h01);
        check("R9 irq after enable", int'(ew_irq), 1);
    endtask

    task automatic t_r10_r11_layout();
        do_reset();
        wr(4'h0, 8'h79);
        rd(4'h0, 8'h00, "R10 ctrl unused bits");
        wr(4'h1, 8'h5A);
        rd(4'h1, 8'h5A, "R10 cfg");
        wr(4'h2, 8'hF7);
        rd(4'h2, 8'h07, "R10 ewofs");
        rd(4'h3, 8'h00, "R10 hole");
        wr(4'h1, 8'hBB);
        wr(4'h0, 8'h82);
        rd(4'h0, 8'h82, "R11 aon set");
        wr(4'h0, 8'h00);
        rd(4'h0, 8'h82, "R11 clear ignored");
        wr(4'h0, 8'h04);
        rd(4'h0, 8'h86, "R11 win still writable");
        do_reset();
        rd(4'h0, 8'h00, "R11 cleared by reset");
    endtask

    task automatic t_r12_busy();
        do_reset();
        wr(4'h1, 8'hB0);
        rd(4'h7, 8'h80, "R12 busy cycle 1");
        step();
        rd(4'h7, 8'h80, "R12 busy cycle 2");
        step();
        rd(4'h7, 8'h00, "R12 busy done");
        wr(4'h2, 8'h03);
        rd(4'h7, 8'h00, "R12 no busy on ewofs");
        wr(4'h8, 8'hA5);
        rd(4'h7, 8'h80, "R12 busy on svc");
    endtask

    task automatic t_r13_disabled();
        int seen = 0;
        do_reset();
        wr(4'h1, 8'hB0);
        wr(4'h8, 8'h00);
        if (rst_req) seen++;
        for (int i = 0; i < 40; i++) begin
            step();
            if (rst_req) seen++;
        end
        check("R13 no reset while off", seen, 0);
    endtask

    initial begin
        t_r1_reset();
        t_r2_r3_timeout();
        t_r4_tick();
        t_r5_r6_service();
        t_r7_window();
        t_r8_r9_warning();
        t_r10_r11_layout();
        t_r12_busy();
        t_r13_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule